// File: doc/BRIEF.md
# Presettable Binary Counter with Terminal-Count Reload

This block is a synchronous binary up counter, eight bits wide by default, that takes a preset word. It runs in one of two modes. In free-running mode it counts through every value and wraps from all-ones back to zero. In reload mode, reaching all-ones makes the next enabled clock edge load the preset word instead of wrapping. With preset P, the counter then divides the clock by 2^W − P.

An active-low terminal-count flag goes low only while every counter bit is one. The flag depends on the counter state alone, so stages can be chained. The inverted flag of one stage drives the count enable of the next stage, and the chain behaves as one wider counter.

A registered carry pair, true and complement, marks each reload with a one-cycle pulse. It serves as the divider output of a single stage that is not chained. A synchronous parallel load overrides every other action. An asynchronous master reset clears the counter at once, without waiting for a clock edge.

Top module: `presettable_counter`

## Requirements
- R1: While `rst_a` is high, the counter reads 0, `carry_out` is 0 and `carry_out_n` is 1. The reset acts without a clock edge.
- R2: `tc_n` is 0 exactly when all counter bits are 1, and is 1 for every other count.
- R3: With `tc_reload_mode` = 0, `load_en` = 0 and `count_en` = 1, the counter steps from all-ones to 0.
- R4: With `tc_reload_mode` = 1, `load_en` = 0 and `count_en` = 1, the counter takes `preset_word` from all-ones instead of wrapping.
- R5: With `load_en` = 0 and `count_en` = 0, the count holds, even at all-ones in reload mode.
- R6: With `load_en` = 1, the next edge loads `preset_word`. This holds whatever `count_en` and `tc_reload_mode` are, and whatever the current count is.
- R7: In every other case with `count_en` = 1, the count rises by exactly one per edge.
- R8: `carry_out` is 1 for the cycle that follows each reload edge, and 0 in all other cycles, including wraps and parallel loads. With preset P, pulses come every 256 − P cycles, so P = 255 holds `carry_out` high.
- R9: `carry_out_n` is always the complement of `carry_out`.
- R10: Two stages chained, with the upper stage's `count_en` driven by the inverted `tc_n` of the lower stage, count as one 16-bit binary counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all counting on its rising edge |
| rst_a | input | 1 | Asynchronous master reset, active high |
| tc_reload_mode | input | 1 | 1: reload preset at all-ones; 0: wrap to zero |
| load_en | input | 1 | Synchronous parallel load of the preset word |
| count_en | input | 1 | Count enable |
| preset_word | input | W (8) | Value taken on load or reload |
| count_q | output | W (8) | Counter state |
| tc_n | output | 1 | Terminal count, low when all bits are one |
| carry_out | output | 1 | Registered reload pulse, true polarity |
| carry_out_n | output | 1 | Registered reload pulse, complement |

## Verification
The hardest situations to reach are the ones at the all-ones state. Three of them matter: a reload in the same cycle as a parallel load, a paused count while the counter sits at all-ones, and back-to-back reloads when the preset is itself all-ones. The stimulus first parks the counter one step below all-ones with a parallel load, then drives the colliding controls on the exact cycle. Divider runs with presets 200, 250, 255 and 0 measure the spacing between carry pulses. A master reset in the middle of a count shows that the reset clears the counter between clock edges. A two-stage chain runs beside the main instance for the whole test, so that every wrap of the low stage is checked against a 16-bit model.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_STEP   = 2'd1,
    ACT_LOAD   = 2'd2,
    ACT_RELOAD = 2'd3
  } pcnt_act_e;

  // Priority: parallel load, then enable gate, then terminal reload, then step.
  function automatic pcnt_act_e pick_action(input logic load,
                                            input logic en,
                                            input logic mode,
                                            input logic term);
    if (load)         return ACT_LOAD;
    if (!en)          return ACT_HOLD;
    if (mode && term) return ACT_RELOAD;
    return ACT_STEP;
  endfunction

endpackage

// File: rtl/pcnt_incr.sv
module pcnt_incr #(
  parameter int W = 8
) (
  input  logic [W-1:0] cur,
  output logic [W-1:0] inc,
  output logic         all_ones
);
  // below[i] is high when every bit under position i is one (toggle enable).
  logic [W:0] below;
  assign below[0] = 1'b1;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign below[i+1] = below[i] & cur[i];
    assign inc[i]     = cur[i] ^ below[i];
  end

  assign all_ones = below[W];
endmodule

// File: rtl/pcnt_ctrl.sv
module pcnt_ctrl
  import pcnt_pkg::*;
(
  input  logic      load,
  input  logic      en,
  input  logic      mode,
  input  logic      term,
  output pcnt_act_e act,
  output logic      reload_evt,
  output logic      take_preset
);
  always_comb begin
    act         = pick_action(load, en, mode, term);
    reload_evt  = (act == ACT_RELOAD);
    take_preset = (act == ACT_RELOAD) || (act == ACT_LOAD);
  end
endmodule

// File: rtl/pcnt_carry.sv
module pcnt_carry (
  input  logic clk,
  input  logic rst_a,
  input  logic reload_evt,
  output logic carry_q,
  output logic carry_qn
);
  logic pulse_r;

  always_ff @(posedge clk or posedge rst_a) begin
    if (rst_a) pulse_r <= 1'b0;
    else       pulse_r <= reload_evt;
  end

  assign carry_q  = pulse_r;
  assign carry_qn = ~pulse_r;
endmodule

// File: rtl/presettable_counter.sv
module presettable_counter
  import pcnt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_a,
  input  logic         tc_reload_mode,
  input  logic         load_en,
  input  logic         count_en,
  input  logic [W-1:0] preset_word,
  output logic [W-1:0] count_q,
  output logic         tc_n,
  output logic         carry_out,
  output logic         carry_out_n
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
  localparam logic [W-1:0] PRE_TERM = ALL_ONES - 1'b1;

  logic [W-1:0] cnt_r;
  logic [W-1:0] cnt_inc;
  logic [W-1:0] cnt_nxt;
  logic         at_term;
  logic         reload_evt;
  logic         take_preset;
  pcnt_act_e    act;

  pcnt_incr #(.W(W)) u_incr (
    .cur      (cnt_r),
    .inc      (cnt_inc),
    .all_ones (at_term)
  );

  pcnt_ctrl u_ctrl (
    .load        (load_en),
    .en          (count_en),
    .mode        (tc_reload_mode),
    .term        (at_term),
    .act         (act),
    .reload_evt  (reload_evt),
    .take_preset (take_preset)
  );

  always_comb begin
    if (take_preset)            cnt_nxt = preset_word;
    else if (act == ACT_STEP)   cnt_nxt = cnt_inc;
    else                        cnt_nxt = cnt_r;
  end

  always_ff @(posedge clk or posedge rst_a) begin
    if (rst_a) cnt_r <= '0;
    else       cnt_r <= cnt_nxt;
  end

  pcnt_carry u_carry (
    .clk        (clk),
    .rst_a      (rst_a),
    .reload_evt (reload_evt),
    .carry_q    (carry_out),
    .carry_qn   (carry_out_n)
  );

  assign count_q = cnt_r;
  assign tc_n    = ~at_term;

  // R1: reset state
  p_reset_state_r1: assert property (@(posedge clk)
    rst_a |-> (count_q == '0 && !carry_out && tc_n));

  // R2: one step short of all-ones leads to an asserted terminal flag
  p_tc_arrive_r2: assert property (@(posedge clk) disable iff (rst_a)
    (!load_en && count_en && count_q == PRE_TERM) |=> !tc_n);

  // R3: wrap in free mode
  p_wrap_r3: assert property (@(posedge clk) disable iff (rst_a)
    (!load_en && count_en && !tc_reload_mode && !tc_n) |=> count_q == '0);

  // R4: reload in reload mode
  p_reload_r4: assert property (@(posedge clk) disable iff (rst_a)
    (!load_en && count_en && tc_reload_mode && !tc_n) |=> count_q == $past(preset_word));

  // R5: hold
  p_hold_r5: assert property (@(posedge clk) disable iff (rst_a)
    (!load_en && !count_en) |=> $stable(count_q));

  // R6: load wins
  p_load_r6: assert property (@(posedge clk) disable iff (rst_a)
    load_en |=> count_q == $past(preset_word));

  // R7: plain step
  p_step_r7: assert property (@(posedge clk) disable iff (rst_a)
    (!load_en && count_en && tc_n) |=> count_q == $past(count_q) + 1'b1);

  // R8: carry follows reload events only
  p_carry_set_r8: assert property (@(posedge clk) disable iff (rst_a)
    reload_evt |=> carry_out);
  p_carry_clr_r8: assert property (@(posedge clk) disable iff (rst_a)
    !reload_evt |=> !carry_out);
endmodule

// File: tb/sim_presettable_counter.sv
module sim_presettable_counter;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_a;
  logic       b_mode, b_load, b_en;
  logic [7:0] b_preset;
  logic [7:0] count_q;
  logic       tc_n, carry_out, carry_out_n;

  // chain of two stages, mode pin tied to its default (low)
  logic       tie_mode;
  logic [7:0] lo_q, hi_q;
  logic       lo_tc_n, hi_tc_n, lo_c, lo_cn, hi_c, hi_cn;

  int n_chk = 0, n_fail = 0;
  int m_cnt, m_car, m16, cyc;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign tie_mode = 1'b0;

  presettable_counter #(.W(8)) u0 (
    .clk(clk), .rst_a(rst_a), .tc_reload_mode(b_mode), .load_en(b_load),
    .count_en(b_en), .preset_word(b_preset), .count_q(count_q), .tc_n(tc_n),
    .carry_out(carry_out), .carry_out_n(carry_out_n));

  presettable_counter #(.W(8)) u_lo (
    .clk(clk), .rst_a(rst_a), .tc_reload_mode(tie_mode), .load_en(1'b0),
    .count_en(1'b1), .preset_word(8'h00), .count_q(lo_q), .tc_n(lo_tc_n),
    .carry_out(lo_c), .carry_out_n(lo_cn));

  presettable_counter #(.W(8)) u_hi (
    .clk(clk), .rst_a(rst_a), .tc_reload_mode(tie_mode), .load_en(1'b0),
    .count_en(~lo_tc_n), .preset_word(8'h00), .count_q(hi_q), .tc_n(hi_tc_n),
    .carry_out(hi_c), .carry_out_n(hi_cn));

  task automatic check(input string tag, input bit ok, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    check(tag,  count_q == m_cnt[7:0], "count", count_q, m_cnt);
    check("R2", tc_n == (m_cnt != 255), "tc_n", tc_n, m_cnt != 255);
    check("R8", carry_out == m_car[0], "carry_out", carry_out, m_car);
    check("R9", carry_out_n == !m_car[0], "carry_out_n", carry_out_n, !m_car[0]);
    check("R10", {hi_q, lo_q} == m16[15:0], "chain16", {hi_q, lo_q}, m16);
  endtask

  // one clock: model the edge, then compare away from it
  task automatic tick();
    string tag;
    @(posedge clk);
    cyc++;
    m16 = (m16 + 1) % 65536;
    m_car = 0;
    if (b_load) begin
      m_cnt = b_preset; tag = "R6";
    end else if (!b_en) begin
      tag = "R5";
    end else if (m_cnt == 255 && b_mode) begin
      m_cnt = b_preset; m_car = 1; tag = "R4";
    end else if (m_cnt == 255) begin
      m_cnt = 0; tag = "R3";
    end else begin
      m_cnt = m_cnt + 1; tag = "R7";
    end
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic park(input logic [7:0] v);
    b_load = 1; b_preset = v; tick(); b_load = 0;
  endtask

  task automatic divider_run(input int p, input int pulses);
    int last, seen;
    last = -1; seen = 0;
    b_mode = 1; b_en = 1; park(p[7:0]);
    while (seen < pulses) begin
      tick();
      if (carry_out) begin
        if (last >= 0)
          check("R8", (cyc - last) == 256 - p, "divide period", cyc - last, 256 - p);
        last = cyc; seen++;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_a = 1; b_mode = 0; b_load = 0; b_en = 0; b_preset = 8'h00;
    m_cnt = 0; m_car = 0; m16 = 0; cyc = 0;
    #1;
    compare_all("R1");
    @(negedge clk); @(negedge clk);
    compare_all("R1");
    rst_a = 0;

    // free running through a wrap (R7, R3)
    b_en = 1;
    for (int i = 0; i < 300; i++) tick();

    // hold, including at all-ones in reload mode (R5)
    b_en = 0;
    for (int i = 0; i < 5; i++) tick();
    b_en = 1; park(8'hFE); tick();        // now at 255
    b_mode = 1; b_en = 0; b_preset = 8'h33;
    for (int i = 0; i < 4; i++) tick();   // R5: stays 255, no carry

    // load beats reload at all-ones (R6), no carry pulse
    b_en = 1; b_load = 1; b_preset = 8'h5A; tick(); b_load = 0;
    // load with enable low (R6)
    b_en = 0; park(8'h12); b_en = 1;
    // wrap in free mode gives no carry (R3)
    b_mode = 0; park(8'hFD);
    for (int i = 0; i < 5; i++) tick();

    // dividers (R4, R8)
    divider_run(200, 4);
    divider_run(250, 5);
    divider_run(255, 4);
    divider_run(0, 3);

    // reset in the middle of a count (R1), checked between edges
    b_mode = 0; park(8'h80);
    for (int i = 0; i < 7; i++) tick();
    #1 rst_a = 1;
    #1;
    m_cnt = 0; m_car = 0; m16 = 0;
    compare_all("R1");
    @(negedge clk);
    compare_all("R1");
    rst_a = 0;
    for (int i = 0; i < 600; i++) tick();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule